// File: doc/BRIEF.md
# Power-State-Aware Initialization Pulse Generator

This block produces the internal initialization signal for a network controller that sits on a shared host bus. The pulse clears configuration space, MAC settings and the memory structures. The block watches the bus reset, an isolate input, an auxiliary-power indicator, a wake-enable bit, the current device power state, a warm-boot request and the bus low-power indication. It also drives a separate clear for the wake context. Two flags, both active while the bus reset is in force, tell the pad ring to float the bus outputs and tell the bus interface to ignore bus inputs.

The bus reset is handled according to the power state. In the active states (D0, D1, D2) its low level holds initialization. In D3 only its release starts a fixed-length pulse, which also marks the return of the bus to full power. While auxiliary power is present, the bus reset is cut off from all logic. The other triggers each start the same fixed-length pulse: isolate release, warm boot and entry to bus low power. Triggers that arrive close together merge into a single pulse that is extended from the latest trigger.

Top module: `pwr_init_gen`

## Requirements
- R1: While `por_n` is low, `init_pulse` and `ctx_rst` are 1 and `float_en` and `ignore_in` are 0. After `por_n` rises, `init_pulse` and `ctx_rst` stay 1 until the PULSE_LEN-th (default 4) rising clock edge, whatever the value of `pme_en`.
- R2: With `pwr_state` set to 0, 1 or 2 (D0, D1, D2) and `aux_pwr` low, `init_pulse` is 1 for exactly as many cycles as the synchronized `bus_rst_n` is low.
- R3: With `pwr_state` = 3 (D3), a low `bus_rst_n` level leaves `init_pulse` at 0. Its synchronized rising edge gives a pulse of exactly PULSE_LEN cycles.
- R4: While the synchronized `aux_pwr` is 1, `bus_rst_n` has no effect on `init_pulse`, `ctx_rst`, `float_en` or `ignore_in`.
- R5: With `pme_en` = 1, once the power-up pulse has ended, `ctx_rst` stays 0 for every trigger.
- R6: With `pme_en` = 0, once the power-up pulse has ended, `ctx_rst` equals `init_pulse`.
- R7: In every power state, `float_en` and `ignore_in` are both 1 exactly while the synchronized `bus_rst_n` is low and the synchronized `aux_pwr` is 0.
- R8: A rising edge of the synchronized `isolate_n` gives an `init_pulse` of PULSE_LEN cycles.
- R9: A `warm_boot` of 1 sampled at a clock edge gives an `init_pulse` of PULSE_LEN cycles, starting after that edge.
- R10: A rising edge of `bus_low_pwr` gives an `init_pulse` of PULSE_LEN cycles. Its falling edge gives none.
- R11: A trigger that arrives while a pulse is running restarts the count. The result is one unbroken pulse that ends PULSE_LEN cycles after the latest trigger.
- R12: `bus_rst_n`, `isolate_n` and `aux_pwr` each pass through SYNC_STAGES (default 2) flops. A change applied between edges shows at the outputs only after the second following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; acts as the power-up request |
| bus_rst_n | input | 1 | Bus reset, active low, asynchronous |
| isolate_n | input | 1 | Isolate input, active low, asynchronous |
| aux_pwr | input | 1 | Auxiliary power present, asynchronous |
| pme_en | input | 1 | Wake (PME) function enabled |
| pwr_state | input | 2 | Device power state, 0 = D0 to 3 = D3 |
| warm_boot | input | 1 | Synchronous warm-boot request |
| bus_low_pwr | input | 1 | Synchronous bus low-power indication; 1 = bus powered down |
| init_pulse | output | 1 | Main initialization for configuration, MAC setup and memories |
| ctx_rst | output | 1 | Clear for the wake context |
| float_en | output | 1 | Float the bus outputs |
| ignore_in | output | 1 | Ignore bus inputs |

## Verification
The main function is exercised with one fixed-length bus-reset pulse, repeated under every combination of power state, auxiliary power and wake enable that changes the outcome. The length of the resulting initialization separates level-held reset (six cycles) from edge-started reset (four cycles) and from a blocked reset (zero). The context-clear count separates preserved wake context from cleared context. Directed cases then drive isolate release, single and overlapping warm boots, both edges of bus low power, and the exact edge at which a synchronized input first reaches an output.

// File: rtl/pwr_init_gen.sv
module pwr_init_gen #(
  parameter int PULSE_LEN   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       bus_rst_n,
  input  logic       isolate_n,
  input  logic       aux_pwr,
  input  logic       pme_en,
  input  logic [1:0] pwr_state,
  input  logic       warm_boot,
  input  logic       bus_low_pwr,
  output logic       init_pulse,
  output logic       ctx_rst,
  output logic       float_en,
  output logic       ignore_in
);

  localparam int            CW    = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LOAD  = CW'(PULSE_LEN);
  localparam logic [1:0]    ST_D3 = 2'd3;

  logic [SYNC_STAGES-1:0] rst_q, iso_q, aux_q;
  logic                   rst_d, iso_d, lowp_d;
  logic [CW-1:0]          cnt, pu_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_q <= '1;
      iso_q <= '1;
      aux_q <= '0;
    end else begin
      rst_q <= {rst_q[SYNC_STAGES-2:0], bus_rst_n};
      iso_q <= {iso_q[SYNC_STAGES-2:0], isolate_n};
      aux_q <= {aux_q[SYNC_STAGES-2:0], aux_pwr};
    end
  end

  wire rst_s = rst_q[SYNC_STAGES-1];
  wire iso_s = iso_q[SYNC_STAGES-1];
  wire aux_s = aux_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_d  <= 1'b1;
      iso_d  <= 1'b1;
      lowp_d <= 1'b0;
    end else begin
      rst_d  <= rst_s;
      iso_d  <= iso_s;
      lowp_d <= bus_low_pwr;
    end
  end

  wire in_d3      = (pwr_state == ST_D3);
  wire bus_rst_on = !rst_s && !aux_s;
  wire level_hold = bus_rst_on && !in_d3;
  wire rst_trail  = rst_s && !rst_d && !aux_s && in_d3;
  wire iso_trail  = iso_s && !iso_d;
  wire lowp_rise  = bus_low_pwr && !lowp_d;
  wire trig       = rst_trail || iso_trail || warm_boot || lowp_rise;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           cnt <= LOAD;
    else if (trig)        cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             pu_cnt <= LOAD;
    else if (pu_cnt != '0)  pu_cnt <= pu_cnt - 1'b1;
  end

  assign init_pulse = (cnt != '0) || level_hold;
  assign ctx_rst    = (pu_cnt != '0) || (init_pulse && !pme_en);
  assign float_en   = bus_rst_on;
  assign ignore_in  = bus_rst_on;

endmodule

// File: rtl/pwr_init_gen_chk.sv
module pwr_init_gen_chk #(
  parameter int PULSE_LEN   = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       por_n,
  input logic       bus_rst_n,
  input logic       aux_pwr,
  input logic       pme_en,
  input logic       warm_boot,
  input logic       bus_low_pwr,
  input logic       init_pulse,
  input logic       ctx_rst,
  input logic       float_en,
  input logic       ignore_in
);

  localparam int            SW   = $clog2(PULSE_LEN + SYNC_STAGES + 2) + 1;
  localparam logic [SW-1:0] SMAX = '1;

  logic [SW-1:0] seen;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            seen <= '0;
    else if (seen != SMAX) seen <= seen + 1'b1;
  end

  AST_POWERUP_PULSE: assert property (@(posedge clk) disable iff (!por_n)
    (int'(seen) < PULSE_LEN) |-> (init_pulse && ctx_rst)); // R1

  AST_AUX_BLOCKS: assert property (@(posedge clk) disable iff (!por_n)
    (int'(seen) >= SYNC_STAGES && $past(aux_pwr, SYNC_STAGES)) |-> (!float_en && !ignore_in)); // R4

  AST_PME_KEEP: assert property (@(posedge clk) disable iff (!por_n)
    (int'(seen) >= PULSE_LEN && pme_en) |-> !ctx_rst); // R5

  AST_CTX_FOLLOW: assert property (@(posedge clk) disable iff (!por_n)
    (int'(seen) >= PULSE_LEN && !pme_en) |-> (ctx_rst == init_pulse)); // R6

  AST_WARM_START: assert property (@(posedge clk) disable iff (!por_n)
    warm_boot |=> init_pulse); // R9

  AST_LOWP_START: assert property (@(posedge clk) disable iff (!por_n)
    (seen != '0 && $rose(bus_low_pwr)) |=> init_pulse); // R10

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!por_n)
    (int'(seen) >= SYNC_STAGES) |->
      (float_en == (!$past(bus_rst_n, SYNC_STAGES) && !$past(aux_pwr, SYNC_STAGES)))); // R12

endmodule

bind pwr_init_gen pwr_init_gen_chk #(.PULSE_LEN(PULSE_LEN), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .por_n(por_n), .bus_rst_n(bus_rst_n), .aux_pwr(aux_pwr), .pme_en(pme_en),
  .warm_boot(warm_boot), .bus_low_pwr(bus_low_pwr), .init_pulse(init_pulse),
  .ctx_rst(ctx_rst), .float_en(float_en), .ignore_in(ignore_in)
);

// File: tb/pwr_init_gen_tb.sv
module pwr_init_gen_tb;
  localparam int CLK_P = 10;
  localparam int PL    = 4;

  // {state[1:0], aux, pme, exp_init[3:0], exp_ctx[3:0], exp_float[3:0]}
  localparam logic [15:0] VEC [8] = '{
    16'h0666, 16'h1606, 16'h4666, 16'h9606,
    16'hC446, 16'hD406, 16'hA000, 16'hF000
  };

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic       por_n = 1'b0, bus_rst_n = 1'b1, isolate_n = 1'b1, aux_pwr = 1'b0;
  logic       pme_en = 1'b0, warm_boot = 1'b0, bus_low_pwr = 1'b0;
  logic [1:0] pwr_state = 2'd0;
  logic       init_pulse, ctx_rst, float_en, ignore_in;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;
  int  ci, cc, cf, cg, rises, mid;
  logic [15:0] e;

  pwr_init_gen #(.PULSE_LEN(PL), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .por_n(por_n), .bus_rst_n(bus_rst_n), .isolate_n(isolate_n),
    .aux_pwr(aux_pwr), .pme_en(pme_en), .pwr_state(pwr_state), .warm_boot(warm_boot),
    .bus_low_pwr(bus_low_pwr), .init_pulse(init_pulse), .ctx_rst(ctx_rst),
    .float_en(float_en), .ignore_in(ignore_in)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tally(input int n);
    logic last;
    last = init_pulse;
    ci = 0; cc = 0; cf = 0; cg = 0; rises = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ci += int'(init_pulse); cc += int'(ctx_rst);
      cf += int'(float_en);   cg += int'(ignore_in);
      if (init_pulse && !last) rises++;
      last = init_pulse;
    end
  endtask

  initial begin
    pme_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 init in reset", int'(init_pulse), 1);
    check("R1 ctx in reset", int'(ctx_rst), 1);
    check("R1 float in reset", int'(float_en), 0);
    check("R1 ignore in reset", int'(ignore_in), 0);
    por_n = 1'b1;
    tally(10);
    check("R1 init after release", ci, PL - 1);
    check("R1 ctx after release with pme_en", cc, PL - 1);

    // R12 synchronizer latency
    @(negedge clk); bus_rst_n = 1'b0;
    @(negedge clk); check("R12 float after one edge", int'(float_en), 0);
    @(negedge clk); check("R12 float after two edges", int'(float_en), 1);
    bus_rst_n = 1'b1;
    repeat (6) @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      e = VEC[v];
      @(negedge clk);
      pwr_state = e[15:14]; aux_pwr = e[13]; pme_en = e[12];
      repeat (4) @(negedge clk);
      bus_rst_n = 1'b0;
      ci = 0; cc = 0; cf = 0; cg = 0; mid = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        ci += int'(init_pulse); cc += int'(ctx_rst);
        cf += int'(float_en);   cg += int'(ignore_in);
        if (i < 6) mid += int'(init_pulse);
        if (i == 5) bus_rst_n = 1'b1;
      end
      check(e[13] ? "R4 init blocked" : (e[15:14] == 2'd3 ? "R3 edge init" : "R2 level init"),
            ci, int'(e[11:8]));
      check(e[13] ? "R4 ctx blocked" : (e[12] ? "R5 ctx kept" : "R6 ctx cleared"),
            cc, int'(e[7:4]));
      check(e[13] ? "R4 float blocked" : "R7 float", cf, int'(e[3:0]));
      check(e[13] ? "R4 ignore blocked" : "R7 ignore", cg, int'(e[3:0]));
      if (e[15:14] == 2'd3) check("R3 level alone in D3", mid, 0);
      aux_pwr = 1'b0;
      repeat (6) @(negedge clk);
    end

    // R8 isolate release, wake context kept
    pwr_state = 2'd0; pme_en = 1'b1;
    @(negedge clk); isolate_n = 1'b0;
    repeat (3) @(negedge clk); isolate_n = 1'b1;
    tally(12);
    check("R8 isolate pulse", ci, PL);
    check("R5 isolate ctx kept", cc, 0);

    // R9 warm boot
    pme_en = 1'b0;
    @(negedge clk); warm_boot = 1'b1;
    @(negedge clk); warm_boot = 1'b0;
    ci = int'(init_pulse);
    tally(10);
    check("R9 warm boot pulse", ci + int'(1'b1), PL);

    // R11 merge
    @(negedge clk); warm_boot = 1'b1;
    @(negedge clk); warm_boot = 1'b0;
    @(negedge clk); warm_boot = 1'b1;
    @(negedge clk); warm_boot = 1'b0;
    tally(10);
    check("R11 merged tail length", ci, PL - 1);
    check("R11 single pulse", rises, 0);

    // R10 bus low-power entry and exit
    @(negedge clk); bus_low_pwr = 1'b1;
    tally(10);
    check("R10 power-down entry pulse", ci, PL);
    bus_low_pwr = 1'b0;
    tally(10);
    check("R10 exit gives no pulse", ci, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule